// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block takes an asynchronous serial line and turns it into received characters. A 16x bit-rate enable pulse comes from outside, and the block uses it to oversample the line. The character format is set at run time. It can carry 5 to 8 data bits and an optional parity bit. When parity is on, the parity is either computed (odd or even) or forced to a fixed level (mark or space). The start bit is validated at mid-bit. The stop bit is sampled and checked.

Each finished character is held in a data register. An 8-bit status word reports the receive flags, the transmit-empty level supplied by the neighbouring transmitter, two modem input levels, and a sticky interrupt-occurred flag. An active-low interrupt line follows that flag.

A pass-through mux drives the transmit line. In echo mode it copies the incoming serial line straight back out. Otherwise it forwards the serial output of the neighbouring transmitter.

Top module: `async_rx_status`

## Requirements
- R1: After reset, status bits 0 to 3 and bit 7 read 0, `irq_n` is 1 and `rx_data` is 0.
- R2: `fmt_len` selects the number of data bits: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5. Bits arrive LSB first, and unused upper bits of `rx_data` read 0.
- R3: With `par_on`=1 and `par_forced`=0, a parity bit follows the data. `par_sel`=1 selects even parity and 0 selects odd. A mismatch sets status bit 0.
- R4: With `par_on`=1 and `par_forced`=1, the parity bit is present but is not checked. `par_sel` 0 means mark and 1 means space. Status bit 0 stays 0 whatever level arrives.
- R5: A stop bit sampled as 0 sets status bit 1 (framing error). The character is still stored.
- R6: If a character completes while status bit 3 (full) is set, status bit 2 (overrun) is set and `rx_data` keeps the older character.
- R7: A one-cycle `data_rd` pulse clears status bits 0 to 3.
- R8: When a character completes and `irq_off`=0, status bit 7 is set and `irq_n` goes low. A `stat_rd` pulse clears both. With `irq_off`=1, completion leaves them unchanged.
- R9: Status bit 5 is the inverse of `dcd_n`, status bit 6 is the inverse of `dsr_n`, and status bit 4 equals `tx_empty`.
- R10: When `echo_on`=1 and `tx_ctl`=00, `tx_out` follows `rx_in`. Otherwise `tx_out` equals `tx_ser`.
- R11: A low pulse on `rx_in` shorter than half a bit time is rejected. The receiver returns to idle and stores no character.
- R12: The receiver advances only on cycles where `tick16` is 1. With `tick16` held at 0 a whole frame is ignored, and with a slower tick the frame is still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| fmt_len | input | 2 | Data-bit count select |
| par_on | input | 1 | Parity bit present |
| par_forced | input | 1 | 1: forced mark/space, unchecked |
| par_sel | input | 1 | Odd/even, or mark/space selector |
| irq_off | input | 1 | 1 disables interrupt setting |
| echo_on | input | 1 | Echo receive line to transmit line |
| tx_ctl | input | 2 | Transmit control field; echo only when 00 |
| tx_ser | input | 1 | Serial output of the neighbouring transmitter |
| tx_empty | input | 1 | Transmit holding register empty level |
| dcd_n | input | 1 | Carrier-detect level, active low |
| dsr_n | input | 1 | Data-set-ready level, active low |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| tx_out | output | 1 | Transmit line |
| rx_data | output | 8 | Received character |
| status | output | 8 | Status word |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Three states are hard to reach from the ports. The first is overrun, which needs a second full frame to finish while the first character is still unread. The bench gets there by sending two frames back to back with no `data_rd`. It then checks that the first character is still in `rx_data`.

The second is a framing error, where the low stop bit could re-trigger the receiver. The bench holds the stop low for only part of the bit, and checks that no phantom character follows.

The third covers the false-start path and the tick gate. For these the bench drives a short glitch, a frame with `tick16` held low, and a frame at one third of the tick rate.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   localparam int unsigned ST_PERR  = 0;
   localparam int unsigned ST_FERR  = 1;
   localparam int unsigned ST_OVR   = 2;
   localparam int unsigned ST_FULL  = 3;
   localparam int unsigned ST_TXE   = 4;
   localparam int unsigned ST_DCD   = 5;
   localparam int unsigned ST_DSR   = 6;
   localparam int unsigned ST_IRQ   = 7;
   localparam int unsigned STATUS_W = 8;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q <= d_in;
            else chain_q <= {chain_q[STAGES-2:0], d_in};
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
   import rxs_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic [1:0]        len_sel,
   input  logic              par_on,
   input  logic              par_forced,
   input  logic              par_sel,
   output logic              done,
   output logic [DATA_W-1:0] char_data,
   output logic              char_perr,
   output logic              char_ferr
);
   localparam int unsigned CW  = $clog2(OSR);
   localparam int unsigned BW  = $clog2(DATA_W);
   localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("rxs_frame: OSR must be even and at least 4");
      end
      if (DATA_W < 8) begin : g_bad_w
         $error("rxs_frame: DATA_W must cover an 8-bit word");
      end
   endgenerate

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic [BW-1:0]     last_bit;
   logic              exp_par;

   assign last_bit  = BW'(DATA_W - 1) - BW'(len_sel);
   assign exp_par   = (^shreg) ^ ~par_sel;
   assign done      = tick && (st == RX_STOP) && (cnt == LAST);
   assign char_data = shreg;
   assign char_ferr = ~rx;
   assign char_perr = par_on && !par_forced && (pbit != exp_par);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         shreg <= '0;
         pbit  <= 1'b0;
      end else if (tick) begin
         unique case (st)
            RX_IDLE: begin
               cnt <= '0;
               if (!rx) st <= RX_START;
            end
            RX_START: begin
               if (cnt == MID) begin
                  cnt   <= '0;
                  bidx  <= '0;
                  shreg <= '0;
                  st    <= rx ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (cnt == LAST) begin
                  cnt         <= '0;
                  shreg[bidx] <= rx;
                  if (bidx == last_bit) st <= par_on ? RX_PAR : RX_STOP;
                  else bidx <= bidx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PAR: begin
               if (cnt == LAST) begin
                  cnt  <= '0;
                  pbit <= rx;
                  st   <= RX_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (cnt == LAST) begin
                  cnt <= '0;
                  st  <= RX_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(st) && $stable(cnt) && $stable(shreg)));

   assert_idle_after_char_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (st == RX_IDLE));
endmodule

// File: rtl/rxs_regs.sv
module rxs_regs
   import rxs_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [DATA_W-1:0]   char_data,
   input  logic                char_perr,
   input  logic                char_ferr,
   input  logic                data_rd,
   input  logic                stat_rd,
   input  logic                irq_off,
   input  logic                tx_empty,
   input  logic                dcd_n,
   input  logic                dsr_n,
   output logic [DATA_W-1:0]   rx_data,
   output logic [STATUS_W-1:0] status,
   output logic                irq_n
);
   logic [DATA_W-1:0] data_q;
   logic full_q, perr_q, ferr_q, ovr_q, irq_q;
   logic irq_set;

   assign irq_set = done && !irq_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         perr_q <= 1'b0;
         ferr_q <= 1'b0;
         ovr_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (data_rd) begin
            full_q <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
         if (done) begin
            if (full_q && !data_rd) begin
               ovr_q <= 1'b1;
            end else begin
               data_q <= char_data;
               full_q <= 1'b1;
               perr_q <= char_perr;
               ferr_q <= char_ferr;
            end
         end
         if (stat_rd) irq_q <= 1'b0;
         if (irq_set) irq_q <= 1'b1;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_PERR] = perr_q;
      status[ST_FERR] = ferr_q;
      status[ST_OVR]  = ovr_q;
      status[ST_FULL] = full_q;
      status[ST_TXE]  = tx_empty;
      status[ST_DCD]  = ~dcd_n;
      status[ST_DSR]  = ~dsr_n;
      status[ST_IRQ]  = irq_q;
   end

   assign rx_data = data_q;
   assign irq_n   = ~irq_q;

   assert_overrun_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full_q && !data_rd) |=> (status[ST_OVR] && $stable(rx_data) && status[ST_FULL]));

   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !done) |=> (status[3:0] == 4'b0000));

   assert_irq_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> !irq_n);

   assert_irq_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !irq_set) |=> irq_n);
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status
   import rxs_pkg::*;
#(
   parameter int unsigned OSR         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_in,
   input  logic       tick16,
   input  logic [1:0] fmt_len,
   input  logic       par_on,
   input  logic       par_forced,
   input  logic       par_sel,
   input  logic       irq_off,
   input  logic       echo_on,
   input  logic [1:0] tx_ctl,
   input  logic       tx_ser,
   input  logic       tx_empty,
   input  logic       dcd_n,
   input  logic       dsr_n,
   input  logic       stat_rd,
   input  logic       data_rd,
   output logic       tx_out,
   output logic [7:0] rx_data,
   output logic [7:0] status,
   output logic       irq_n
);
   localparam int unsigned DATA_W = 8;

   logic              rx_s;
   logic              done;
   logic [DATA_W-1:0] char_data;
   logic              char_perr, char_ferr;

   rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rx_s)
   );

   rxs_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .len_sel(fmt_len), .par_on(par_on), .par_forced(par_forced),
      .par_sel(par_sel), .done(done), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr)
   );

   rxs_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .done(done), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr), .data_rd(data_rd),
      .stat_rd(stat_rd), .irq_off(irq_off), .tx_empty(tx_empty),
      .dcd_n(dcd_n), .dsr_n(dsr_n), .rx_data(rx_data), .status(status),
      .irq_n(irq_n)
   );

   assign tx_out = (echo_on && (tx_ctl == 2'b00)) ? rx_in : tx_ser;
endmodule

// File: tb/async_rx_status_tb_top.sv
module async_rx_status_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_in = 1'b1, tick16 = 1'b0;
   logic [1:0] fmt_len = 2'b00;
   logic par_on = 1'b0, par_forced = 1'b0, par_sel = 1'b0, irq_off = 1'b0;
   logic echo_on = 1'b0;
   logic [1:0] tx_ctl = 2'b00;
   logic tx_ser = 1'b0, tx_empty = 1'b0, dcd_n = 1'b1, dsr_n = 1'b1;
   logic stat_rd = 1'b0, data_rd = 1'b0;
   logic tx_out, irq_n;
   logic [7:0] rx_data, status;

   int checks = 0;
   int failures = 0;
   int tick_div = 1;
   int tcnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (tick_div == 0) begin
         tick16 <= 1'b0;
         tcnt   <= 0;
      end else begin
         tick16 <= (tcnt == 0);
         tcnt   <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
      end
   end

   async_rx_status dut_i (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
      .fmt_len(fmt_len), .par_on(par_on), .par_forced(par_forced),
      .par_sel(par_sel), .irq_off(irq_off), .echo_on(echo_on),
      .tx_ctl(tx_ctl), .tx_ser(tx_ser), .tx_empty(tx_empty),
      .dcd_n(dcd_n), .dsr_n(dsr_n), .stat_rd(stat_rd), .data_rd(data_rd),
      .tx_out(tx_out), .rx_data(rx_data), .status(status), .irq_n(irq_n)
   );

   typedef struct packed {
      logic [1:0] len;
      logic       pen;
      logic       forced;
      logic       sel;
      logic       badp;
      logic       bads;
      logic [7:0] data;
      logic [7:0] exp;
      logic [1:0] err;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 2'b00},
      '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h25, 2'b00},
      '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h3F, 2'b00},
      '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h1A, 2'b00},
      '{2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03, 8'h03, 2'b00},
      '{2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h03, 8'h03, 2'b01},
      '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07, 8'h07, 2'b00},
      '{2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 8'h07, 2'b01},
      '{2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'hC3, 2'b00},
      '{2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC3, 8'hC3, 2'b00},
      '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h81, 2'b10},
      '{2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h1F, 8'h1F, 2'b01},
      '{2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h2A, 8'h2A, 2'b10}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nb, input logic has_p,
                       input logic p, input logic stop_ok, input int per);
      @(negedge clk);
      rx_in = 1'b0;
      idle(per);
      for (int i = 0; i < nb; i++) begin
         rx_in = d[i];
         idle(per);
      end
      if (has_p) begin
         rx_in = p;
         idle(per);
      end
      if (stop_ok) begin
         rx_in = 1'b1;
         idle(per);
      end else begin
         rx_in = 1'b0;
         idle((per * 3) / 4);
         rx_in = 1'b1;
         idle(per / 4);
      end
      rx_in = 1'b1;
      idle(per * 2);
   endtask

   task automatic pulse_data_rd;
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
   endtask

   task automatic pulse_stat_rd;
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   function automatic logic par_bit(input vec_t v);
      logic [7:0] dm;
      dm = v.data & (8'hFF >> v.len);
      if (!v.forced) par_bit = v.sel ? (^dm) : ~(^dm);
      else           par_bit = v.sel ? 1'b0 : 1'b1;
      par_bit = par_bit ^ v.badp;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk("R1 status", status, 8'h00);
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
      chk("R1 rx_data", rx_data, 8'h00);

      // vector table: R2 R3 R4 R5 R7 R8
      for (int k = 0; k < NV; k++) begin
         fmt_len    = VEC[k].len;
         par_on     = VEC[k].pen;
         par_forced = VEC[k].forced;
         par_sel    = VEC[k].sel;
         send(VEC[k].data, 8 - int'(VEC[k].len), VEC[k].pen, par_bit(VEC[k]), !VEC[k].bads, 16);
         chk("R2 data", rx_data, VEC[k].exp);
         chk("R3 R4 R5 flags", {4'b0, status[3:0]}, {4'b0, 2'b10, VEC[k].err});
         chk("R8 irq low", {7'b0, irq_n}, 8'h00);
         pulse_stat_rd();
         chk("R8 irq cleared", {status[7], 6'b0, irq_n}, 8'h01);
         pulse_data_rd();
         chk("R7 cleared", {4'b0, status[3:0]}, 8'h00);
      end

      fmt_len = 2'b00; par_on = 1'b0; par_forced = 1'b0; par_sel = 1'b0;

      // R6 overrun
      send(8'h11, 8, 1'b0, 1'b0, 1'b1, 16);
      send(8'h22, 8, 1'b0, 1'b0, 1'b1, 16);
      chk("R6 ovr flags", {4'b0, status[3:0]}, 8'h0C);
      chk("R6 data kept", rx_data, 8'h11);
      pulse_data_rd();
      chk("R7 ovr cleared", {4'b0, status[3:0]}, 8'h00);
      pulse_stat_rd();

      // R8 masked interrupt
      irq_off = 1'b1;
      send(8'h3C, 8, 1'b0, 1'b0, 1'b1, 16);
      chk("R8 masked irq_n", {status[7], 6'b0, irq_n}, 8'h01);
      chk("R8 masked data", rx_data, 8'h3C);
      pulse_data_rd();
      irq_off = 1'b0;

      // R9 pin levels
      dcd_n = 1'b0; dsr_n = 1'b1; tx_empty = 1'b1;
      idle(1);
      chk("R9 pins a", {5'b0, status[6:4]}, 8'h03);
      dcd_n = 1'b1; dsr_n = 1'b0; tx_empty = 1'b0;
      idle(1);
      chk("R9 pins b", {5'b0, status[6:4]}, 8'h04);
      dsr_n = 1'b1;

      // R10 echo
      echo_on = 1'b1; tx_ctl = 2'b00; tx_ser = 1'b1;
      rx_in = 1'b0;
      idle(1);
      chk("R10 echo low", {7'b0, tx_out}, 8'h00);
      rx_in = 1'b1; tx_ser = 1'b0;
      idle(1);
      chk("R10 echo high", {7'b0, tx_out}, 8'h01);
      tx_ctl = 2'b01; tx_ser = 1'b0;
      idle(1);
      chk("R10 no echo", {7'b0, tx_out}, 8'h00);
      echo_on = 1'b0; tx_ctl = 2'b00;
      idle(40);

      // R11 false start
      rx_in = 1'b0;
      idle(4);
      rx_in = 1'b1;
      idle(60);
      chk("R11 glitch ignored", {4'b0, status[3:0]}, 8'h00);
      chk("R11 irq idle", {7'b0, irq_n}, 8'h01);
      send(8'h6E, 8, 1'b0, 1'b0, 1'b1, 16);
      chk("R11 next char", rx_data, 8'h6E);
      pulse_data_rd();
      pulse_stat_rd();

      // R12 tick gating
      tick_div = 0;
      idle(2);
      send(8'h99, 8, 1'b0, 1'b0, 1'b1, 16);
      chk("R12 no tick no char", {4'b0, status[3:0]}, 8'h00);
      chk("R12 data unchanged", rx_data, 8'h6E);
      tick_div = 3;
      idle(3);
      send(8'hB4, 8, 1'b0, 1'b0, 1'b1, 48);
      chk("R12 slow tick data", rx_data, 8'hB4);
      chk("R12 slow tick flags", {4'b0, status[3:0]}, 8'h08);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule